// File: doc/BRIEF.md
# Dual-Granularity SPI Serial Clock Generator

This block makes the serial clock for one SPI channel from a fixed reference clock. Software picks one of two divide modes with a granularity bit. The power-of-two mode divides the reference by 2^k, where k is a 4-bit field. The linear mode divides by any integer from 1 to 4096. In linear mode the divisor minus one is a 12-bit value. Its four low bits come from the same 4-bit field, and its eight high bits come from a separate extension field.

A channel enable starts and stops the clock. While the channel is off, the counter is held cleared and the serial clock sits at the idle level that CPOL selects. The block also drives two strobes, each one reference cycle wide. The launch strobe tells a shifter when to drive the next bit and the sample strobe tells it when to capture. Which strobe goes with which clock edge depends on CPHA. A new divisor is taken only when the channel is enabled or at the end of a full clock period, so the clock never has a shortened pulse.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is high, and in every cycle after a reference edge at which `chan_en` was sampled low, `sclk` equals `cpol` and both strobes are 0.
- R2: With `gran_sel` = 0, the period of `sclk` is 2^`clkd` reference cycles, for `clkd` from 0 to 15.
- R3: With `gran_sel` = 1, the period of `sclk` is ({`ext_div`,`clkd`} + 1) reference cycles, with `ext_div` as the upper eight bits. This gives periods from 1 to 4096.
- R4: For a period n ≥ 2, the active phase comes first and lasts floor(n/2) cycles, and the idle phase lasts the other n − floor(n/2) cycles. Cycle 0 of the first period is the cycle right after the first reference edge at which `chan_en` is sampled high.
- R5: For a period of 1, `sclk` follows the reference clock: it is at the active level while the reference is high and at `cpol` while the reference is low.
- R6: The idle level of `sclk` is `cpol` and the active level is its inverse, in all four SPI modes.
- R7: The leading edge is idle-to-active and the trailing edge is active-to-idle. With `cpha` = 0, `sample_edge` goes with the leading edge and `launch_edge` with the trailing edge. With `cpha` = 1 the roles swap. Each strobe is high for exactly the first reference cycle after its edge.
- R8: A change to `gran_sel`, `clkd` or `ext_div` while the channel is running takes effect at the start of the next period. The period in progress keeps its old length.
- R9: Dropping `chan_en` in the middle of a period returns `sclk` to idle one cycle later, with no strobe. The next enable starts a fresh period at cycle 0.
- R10: While the period is 1, `launch_edge` and `sample_edge` are both high in every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 1 | Channel enable |
| gran_sel | input | 1 | 0: power-of-two divide, 1: linear divide |
| clkd | input | CLKD_W | Exponent (power-of-two mode) or low divisor bits (linear mode) |
| ext_div | input | EXT_W | High divisor bits, used in linear mode |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Selects which edge is used for sampling |
| sclk | output | 1 | Serial clock |
| launch_edge | output | 1 | One-cycle strobe at the data launch edge |
| sample_edge | output | 1 | One-cycle strobe at the data sample edge |

## Verification
The bench sweeps every linear divisor from 1 to 32, the largest linear divisor 4096, and the power-of-two exponents 0 to 10 and 15, and rotates through the four SPI modes as it goes. Each run is compared cycle by cycle against a model of the period, so a design that got the split between the fields wrong, or dropped the +1, would have the wrong period. Odd divisors check the floor/remainder split of the phases, where an off-by-one would make one phase too long. Divide-by-1 is sampled in both halves of the reference cycle, since a design without the bypass would hold `sclk` flat. The bench also changes the divisor mid-period and disables the channel mid-phase, which catch a design that reloads at once (a short pulse) or that emits a strobe when it stops.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    typedef enum logic {
        GRAN_POW2   = 1'b0,
        GRAN_LINEAR = 1'b1
    } gran_e;

    // Edge events of the serial clock, in terms of idle/active level
    typedef struct packed {
        logic lead;   // idle -> active
        logic trail;  // active -> idle
    } edge_pair_t;

    // Data strobes after mapping by clock phase
    typedef struct packed {
        logic launch;
        logic sample;
    } strobe_t;

    function automatic strobe_t map_strobes(edge_pair_t e, logic phase);
        strobe_t s;
        s.launch = phase ? e.lead  : e.trail;
        s.sample = phase ? e.trail : e.lead;
        return s;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_div_select.sv
module spi_div_select
    import spi_sclk_pkg::*;
#(
    parameter int CLKD_W = 4,
    parameter int EXT_W  = 8,
    parameter int DIV_W  = 16
) (
    input  gran_e              gran,
    input  logic [CLKD_W-1:0]  clkd,
    input  logic [EXT_W-1:0]   ext_div,
    output logic [DIV_W-1:0]   div_n,
    output logic [DIV_W-1:0]   half_n
);
    logic [DIV_W-1:0] lin_div;
    logic [DIV_W-1:0] pow_div;

    always_comb begin
        lin_div = DIV_W'({ext_div, clkd}) + DIV_W'(1);
        pow_div = DIV_W'(1) << clkd;
        div_n   = (gran == GRAN_LINEAR) ? lin_div : pow_div;
        half_n  = div_n >> 1;
    end

endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase
    import spi_sclk_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_n,
    input  logic [DIV_W-1:0]  half_n,
    output logic              run_q,
    output logic [DIV_W-1:0]  cnt_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              act_q,
    output logic              byp_q,
    output edge_pair_t        edges_q
);
    logic [DIV_W-1:0] half_q;
    logic             wrap;
    logic             run_n;
    logic [DIV_W-1:0] cnt_n;
    logic [DIV_W-1:0] div_nx;
    logic [DIV_W-1:0] half_nx;
    logic             act_n;
    logic             byp_n;
    edge_pair_t       edges_n;

    always_comb begin
        wrap    = run_q && (cnt_q == div_q - DIV_W'(1));
        run_n   = run_q;
        cnt_n   = cnt_q;
        div_nx  = div_q;
        half_nx = half_q;
        if (!en) begin
            run_n = 1'b0;
            cnt_n = '0;
        end else if (!run_q || wrap) begin
            // fresh period: only point where a new divisor is taken
            run_n   = 1'b1;
            cnt_n   = '0;
            div_nx  = div_n;
            half_nx = half_n;
        end else begin
            cnt_n = cnt_q + DIV_W'(1);
        end
        act_n         = run_n && (cnt_n < half_nx);
        byp_n         = run_n && (div_nx == DIV_W'(1));
        edges_n.lead  = run_n && (byp_n || (act_n && !act_q));
        edges_n.trail = run_n && (byp_n || (run_q && act_q && !act_n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            div_q   <= '0;
            half_q  <= '0;
            act_q   <= 1'b0;
            byp_q   <= 1'b0;
            edges_q <= '0;
        end else begin
            run_q   <= run_n;
            cnt_q   <= cnt_n;
            div_q   <= div_nx;
            half_q  <= half_nx;
            act_q   <= act_n;
            byp_q   <= byp_n;
            edges_q <= edges_n;
        end
    end

endmodule

// File: rtl/spi_sclk_out.sv
module spi_sclk_out
    import spi_sclk_pkg::*;
(
    input  logic       clk,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       act_q,
    input  logic       byp_q,
    input  edge_pair_t edges_q,
    output logic       sclk,
    output logic       launch_edge,
    output logic       sample_edge
);
    strobe_t strobes;

    always_comb begin
        // divide-by-1 lets the reference through; otherwise a registered level
        sclk        = cpol ^ (act_q | (byp_q & clk));
        strobes     = map_strobes(edges_q, cpha);
        launch_edge = strobes.launch;
        sample_edge = strobes.sample;
    end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int CLKD_W = 4,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              gran_sel,
    input  logic [CLKD_W-1:0] clkd,
    input  logic [EXT_W-1:0]  ext_div,
    input  logic              cpol,
    input  logic              cpha,
    output logic              sclk,
    output logic              launch_edge,
    output logic              sample_edge
);
    localparam int POW_W = 1 << CLKD_W;
    localparam int LIN_W = CLKD_W + EXT_W + 1;
    localparam int DIV_W = max_int(POW_W, LIN_W);

    logic [DIV_W-1:0] div_n;
    logic [DIV_W-1:0] half_n;
    logic             run_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             act_q;
    logic             byp_q;
    edge_pair_t       edges_q;
    gran_e            gran;

    assign gran = gran_e'(gran_sel);

    spi_div_select #(
        .CLKD_W (CLKD_W),
        .EXT_W  (EXT_W),
        .DIV_W  (DIV_W)
    ) u_sel (
        .gran    (gran),
        .clkd    (clkd),
        .ext_div (ext_div),
        .div_n   (div_n),
        .half_n  (half_n)
    );

    spi_div_phase #(
        .DIV_W (DIV_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .en      (chan_en),
        .div_n   (div_n),
        .half_n  (half_n),
        .run_q   (run_q),
        .cnt_q   (cnt_q),
        .div_q   (div_q),
        .act_q   (act_q),
        .byp_q   (byp_q),
        .edges_q (edges_q)
    );

    spi_sclk_out u_out (
        .clk         (clk),
        .cpol        (cpol),
        .cpha        (cpha),
        .act_q       (act_q),
        .byp_q       (byp_q),
        .edges_q     (edges_q),
        .sclk        (sclk),
        .launch_edge (launch_edge),
        .sample_edge (sample_edge)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_en,
    input logic             cpol,
    input logic             sclk,
    input logic             launch_edge,
    input logic             sample_edge,
    input logic             run_q,
    input logic [DIV_W-1:0] cnt_q,
    input logic [DIV_W-1:0] div_q,
    input logic             byp_q
);
    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!chan_en) |-> (sclk == cpol));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!chan_en) |-> (!launch_edge && !sample_edge));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !byp_q |-> !(launch_edge && sample_edge));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < div_q));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && (div_q != $past(div_q))) |-> (cnt_q == '0));

    // R10
    byp_both_chk: assert property (@(posedge clk) disable iff (rst)
        byp_q |-> (launch_edge && sample_edge));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .chan_en     (chan_en),
    .cpol        (cpol),
    .sclk        (sclk),
    .launch_edge (launch_edge),
    .sample_edge (sample_edge),
    .run_q       (run_q),
    .cnt_q       (cnt_q),
    .div_q       (div_q),
    .byp_q       (byp_q)
);

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       chan_en;
    logic       gran_sel;
    logic [3:0] clkd;
    logic [7:0] ext_div;
    logic       cpol;
    logic       cpha;
    logic       sclk;
    logic       launch_edge;
    logic       sample_edge;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spi_sclk_gen uut (
        .clk         (clk),
        .rst         (rst),
        .chan_en     (chan_en),
        .gran_sel    (gran_sel),
        .clkd        (clkd),
        .ext_div     (ext_div),
        .cpol        (cpol),
        .cpha        (cpha),
        .sclk        (sclk),
        .launch_edge (launch_edge),
        .sample_edge (sample_edge)
    );

    function automatic int div_of(logic g, logic [3:0] cd, logic [7:0] ex);
        return g ? (int'({ex, cd}) + 1) : (1 << cd);
    endfunction

    // Runs one configuration from a fresh enable; optionally switches config after cycle sw_k
    task automatic run_check(input string tag, input logic g, input logic [3:0] cd,
                             input logic [7:0] ex, input logic cp, input logic ch,
                             input int cycles, input int sw_k, input logic g2,
                             input logic [3:0] cd2, input logic [7:0] ex2);
        int n_cur;
        int base;
        int pos;
        int h;
        int bad;
        logic [2:0] first_act;
        logic [2:0] first_exp;
        logic exp_hi;
        logic exp_lo;
        logic lead;
        logic trail;
        logic exp_l;
        logic exp_s;
        @(posedge clk); #1;
        chan_en = 1'b0; gran_sel = g; clkd = cd; ext_div = ex; cpol = cp; cpha = ch;
        @(posedge clk); #1;
        chan_en = 1'b1;
        n_cur = div_of(g, cd, ex);
        base = 0;
        bad = 0;
        first_act = '0;
        first_exp = '0;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            if (k - base == n_cur) begin
                base  = k;
                n_cur = (sw_k >= 0 && k > sw_k) ? div_of(g2, cd2, ex2) : div_of(g, cd, ex);
            end
            pos = k - base;
            h   = n_cur / 2;
            #1;
            exp_hi = (n_cur == 1) ? ~cp : (cp ^ (pos < h));
            if (sclk !== exp_hi) begin
                if (bad == 0) begin
                    first_act = {sclk, 2'b00};
                    first_exp = {exp_hi, 2'b00};
                end
                bad++;
            end
            if (k == sw_k) begin
                gran_sel = g2; clkd = cd2; ext_div = ex2;
            end
            #2;
            exp_lo = (n_cur == 1) ? cp : (cp ^ (pos < h));
            lead   = (n_cur == 1) || (pos == 0);
            trail  = (n_cur == 1) || (pos == h);
            exp_l  = ch ? lead : trail;
            exp_s  = ch ? trail : lead;
            if ({sclk, launch_edge, sample_edge} !== {exp_lo, exp_l, exp_s}) begin
                if (bad == 0) begin
                    first_act = {sclk, launch_edge, sample_edge};
                    first_exp = {exp_lo, exp_l, exp_s};
                end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s div=%0d cpol=%0d cpha=%0d mismatches=%0d actual{sclk,launch,sample}=%b expected=%b",
                     tag, div_of(g, cd, ex), cp, ch, bad, first_act, first_exp);
        end
    endtask

    // R9: disable in the middle of a running period
    task automatic check_stop(input string tag);
        logic cp_now;
        @(posedge clk); #1;
        chan_en = 1'b0;
        cp_now  = cpol;
        @(posedge clk); #3;
        checks++;
        if ({sclk, launch_edge, sample_edge} !== {cp_now, 2'b00}) begin
            failures++;
            $display("FAIL %s stop actual=%b expected=%b", tag,
                     {sclk, launch_edge, sample_edge}, {cp_now, 2'b00});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; chan_en = 1'b0; gran_sel = 1'b0; clkd = '0; ext_div = '0;
        cpol = 1'b1; cpha = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        checks++;
        if ({sclk, launch_edge, sample_edge} !== 3'b100) begin
            failures++;
            $display("FAIL R1 reset actual=%b expected=100", {sclk, launch_edge, sample_edge});
        end
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        checks++;
        if ({sclk, launch_edge, sample_edge} !== 3'b100) begin
            failures++;
            $display("FAIL R1 disabled actual=%b expected=100", {sclk, launch_edge, sample_edge});
        end

        // R3 / R4 / R6 / R7: linear divisors 1..32 across all four modes
        for (int v = 0; v < 32; v++) begin
            int n = v + 1;
            run_check("R3", 1'b1, 4'(v), 8'(v >> 4), v[0], v[1],
                      2 * n + 3, -1, 1'b0, 4'd0, 8'd0);
        end
        // R3 largest linear divisor
        run_check("R3", 1'b1, 4'hF, 8'hFF, 1'b0, 1'b1, 4096 + 10, -1, 1'b0, 4'd0, 8'd0);
        // R2 power-of-two exponents
        for (int e = 0; e <= 10; e++) begin
            run_check("R2", 1'b0, 4'(e), 8'hA5, e[1], e[0],
                      (1 << e) + ((1 << e) / 2) + 2, -1, 1'b0, 4'd0, 8'd0);
        end
        run_check("R2", 1'b0, 4'd15, 8'h00, 1'b1, 1'b0, 32768 + 4, -1, 1'b0, 4'd0, 8'd0);
        // R4 odd split, R6 idle level, R7 phase roles, n=7
        for (int m = 0; m < 4; m++) begin
            run_check("R4_R6_R7", 1'b1, 4'd6, 8'd0, m[1], m[0], 20, -1, 1'b0, 4'd0, 8'd0);
        end
        // R5 / R10 divide-by-1 in both modes
        run_check("R5_R10", 1'b1, 4'd0, 8'd0, 1'b0, 1'b0, 8, -1, 1'b0, 4'd0, 8'd0);
        run_check("R5_R10", 1'b0, 4'd0, 8'd0, 1'b1, 1'b1, 8, -1, 1'b0, 4'd0, 8'd0);
        // R8: config changes mid-period
        run_check("R8", 1'b1, 4'd5, 8'd0, 1'b0, 1'b0, 30, 2, 1'b1, 4'd9, 8'd0);
        run_check("R8", 1'b1, 4'd9, 8'd0, 1'b1, 1'b1, 20, 3, 1'b1, 4'd0, 8'd0);
        run_check("R8", 1'b1, 4'd0, 8'd0, 1'b0, 1'b1, 14, 0, 1'b0, 4'd2, 8'd0);
        run_check("R8", 1'b0, 4'd3, 8'd0, 1'b1, 1'b0, 30, 5, 1'b1, 4'd2, 8'd0);
        // R9: stop mid-active and mid-idle, then fresh start
        run_check("R9", 1'b1, 4'd7, 8'd0, 1'b0, 1'b0, 2, -1, 1'b0, 4'd0, 8'd0);
        check_stop("R9");
        run_check("R9", 1'b1, 4'd7, 8'd0, 1'b1, 1'b1, 6, -1, 1'b0, 4'd0, 8'd0);
        check_stop("R9");
        run_check("R9", 1'b1, 4'd7, 8'd0, 1'b1, 1'b0, 18, -1, 1'b0, 4'd0, 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule